// File: doc/BRIEF.md
# Triggered Hold Slot Pointer with Crossing Stamp

This block manages the write address of a small multi-slot analog sample memory that sits in front of a front-end readout chip's converter. A running bunch-crossing number advances once per machine crossing. On each crossing the front end takes a synchronous hold. If any channel trigger is active on that crossing, or an external force trigger is present, the hold is kept. The slot address then moves to the next cell, and the crossing number is written into a small digital memory that pairs with that slot.

An acquisition window opens with a one-cycle start pulse. The pulse clears the crossing counter and the slot pointer. Once every slot is used, further triggers are dropped until the next window. During readout the stored crossing numbers are fetched by slot index. The slot address also gives the number of filled slots.

Top module: `bx_hold_ptr`

## Requirements
- R1: After reset, `slot_addr` is 0, `bx_now` is 0, `mem_full` is 0 and `hold` is 0.
- R2: Each cycle with `bx_sync` high (and `acq_start` low) raises `bx_now` by exactly 1 in the next cycle. Without `bx_sync`, `bx_now` keeps its value.
- R3: `hold` is high in the cycle after each `bx_sync` and low in the cycle after any cycle without `bx_sync`.
- R4: A crossing (`bx_sync` high) with any bit of `ch_trig` set, while the memory is not full, raises `slot_addr` by 1 in the next cycle. Any channel from 0 to 35 counts. A trigger without `bx_sync` changes nothing.
- R5: A crossing with `ch_trig` all zero and `force_trig` low leaves `slot_addr` unchanged.
- R6: `force_trig` on a crossing validates the hold on its own, with `ch_trig` all zero.
- R7: A validated hold writes the value `bx_now` had on that crossing (before it increments) into slot `slot_addr`. `rd_bx` returns the word stored in slot `rd_slot` (index 0 is the first slot filled), combinationally.
- R8: `mem_full` is high exactly when `slot_addr` equals 5. While it is high, triggers leave `slot_addr` at 5 and do not change any stored word.
- R9: `rd_bx` is 0 whenever `rd_slot` is not below `slot_addr`, which covers unfilled slots and indices 5 to 7.
- R10: `acq_start` clears `bx_now`, `slot_addr`, `mem_full` and `hold` in the next cycle. It takes priority over a `bx_sync` or trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | One-cycle pulse opening an acquisition window |
| bx_sync | input | 1 | One-cycle pulse marking a bunch crossing |
| ch_trig | input | 36 | Per-channel trigger flags |
| force_trig | input | 1 | External trigger that validates the hold on its own |
| hold | output | 1 | Hold strobe, one cycle after each crossing |
| slot_addr | output | 3 | Current analog slot address, which is also the count of filled slots |
| mem_full | output | 1 | All slots filled |
| bx_now | output | 24 | Running bunch-crossing number |
| rd_slot | input | 3 | Readout slot index |
| rd_bx | output | 24 | Crossing number stored in slot `rd_slot`, or 0 |

## Verification
The checker covers the per-cycle rules in every cycle: the counter step and hold on crossings, the hold strobe, the pointer advancing only on validated crossings, the pointer saturating at full, and the clear on window start. The bench scenarios are the only evidence for the data path. This includes which crossing number lands in which slot, that saturated triggers leave stored words alone, and that reads of unfilled indices return zero. These depend on the value history, which the properties do not track.

// File: rtl/bx_hold_ptr.sv
module bx_hold_ptr #(
  parameter int NUM_CH    = 36,
  parameter int NUM_SLOTS = 5,
  parameter int BX_W      = 24,
  localparam int PTR_W    = $clog2(NUM_SLOTS + 1),
  localparam int RD_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_start,
  input  logic              bx_sync,
  input  logic [NUM_CH-1:0] ch_trig,
  input  logic              force_trig,
  output logic              hold,
  output logic [PTR_W-1:0]  slot_addr,
  output logic              mem_full,
  output logic [BX_W-1:0]   bx_now,
  input  logic [RD_W-1:0]   rd_slot,
  output logic [BX_W-1:0]   rd_bx
);

  logic [BX_W-1:0]  bx_cnt;
  logic [PTR_W-1:0] wr_ptr;
  logic             hold_q;
  logic [BX_W-1:0]  stamp [NUM_SLOTS];

  wire any_trig = (|ch_trig) | force_trig;
  wire full     = (wr_ptr == PTR_W'(NUM_SLOTS));
  wire take     = bx_sync & any_trig & ~full & ~acq_start;

  always_ff @(posedge clk) begin
    if (!rst_n || acq_start) begin
      bx_cnt <= '0;
      wr_ptr <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= bx_sync;
      if (bx_sync) bx_cnt <= bx_cnt + 1'b1;
      if (take)    wr_ptr <= wr_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk)
      if (rst_n && take && wr_ptr == PTR_W'(g)) stamp[g] <= bx_cnt;
  end

  always_comb begin
    rd_bx = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (rd_slot == RD_W'(i) && PTR_W'(i) < wr_ptr) rd_bx = stamp[i];
  end

  assign hold      = hold_q;
  assign slot_addr = wr_ptr;
  assign mem_full  = full;
  assign bx_now    = bx_cnt;

endmodule

// File: rtl/bx_hold_ptr_chk.sv
module bx_hold_ptr_chk #(
  parameter int NUM_CH    = 36,
  parameter int NUM_SLOTS = 5,
  parameter int BX_W      = 24,
  parameter int PTR_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acq_start,
  input logic              bx_sync,
  input logic [NUM_CH-1:0] ch_trig,
  input logic              force_trig,
  input logic              hold,
  input logic [PTR_W-1:0]  slot_addr,
  input logic              mem_full,
  input logic [BX_W-1:0]   bx_now
);

  wire valid = bx_sync && ((|ch_trig) || force_trig);

  AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bx_sync && !acq_start |=> (bx_now - $past(bx_now)) == BX_W'(1)); // R2
  AST_BX_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_sync && !acq_start |=> $stable(bx_now)); // R2
  AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    bx_sync && !acq_start |=> hold); // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_sync |=> !hold); // R3
  AST_PTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !mem_full && !acq_start |=> slot_addr == $past(slot_addr) + 1'b1); // R4
  AST_PTR_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !acq_start |=> $stable(slot_addr)); // R5
  AST_FULL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full && !acq_start |=> mem_full && slot_addr == PTR_W'(NUM_SLOTS)); // R8
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full == (slot_addr == PTR_W'(NUM_SLOTS))); // R8
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> slot_addr == '0 && bx_now == '0 && !hold); // R10

endmodule

bind bx_hold_ptr bx_hold_ptr_chk #(
  .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .BX_W(BX_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .bx_sync(bx_sync),
  .ch_trig(ch_trig), .force_trig(force_trig), .hold(hold),
  .slot_addr(slot_addr), .mem_full(mem_full), .bx_now(bx_now)
);

// File: tb/sim_bx_hold_ptr.sv
`timescale 1ns/1ps
module sim_bx_hold_ptr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acq_start = 1'b0;
  logic        bx_sync = 1'b0;
  logic [35:0] ch_trig = '0;
  logic        force_trig = 1'b0;
  logic        hold;
  logic [2:0]  slot_addr;
  logic        mem_full;
  logic [23:0] bx_now;
  logic [2:0]  rd_slot = '0;
  logic [23:0] rd_bx;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bx_hold_ptr u0 (.*);

  // {sync, force, ch_en, ch[5:0], exp_slot[2:0], exp_bx[7:0]}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 6'd0,  3'd0, 8'd1},
    {1'b0, 1'b0, 1'b1, 6'd5,  3'd0, 8'd1},
    {1'b1, 1'b0, 1'b1, 6'd0,  3'd1, 8'd2},
    {1'b1, 1'b0, 1'b1, 6'd35, 3'd2, 8'd3},
    {1'b1, 1'b0, 1'b0, 6'd0,  3'd2, 8'd4},
    {1'b1, 1'b1, 1'b0, 6'd0,  3'd3, 8'd5},
    {1'b0, 1'b0, 1'b0, 6'd0,  3'd3, 8'd5},
    {1'b1, 1'b0, 1'b1, 6'd17, 3'd4, 8'd6},
    {1'b1, 1'b1, 1'b1, 6'd17, 3'd5, 8'd7},
    {1'b1, 1'b0, 1'b1, 6'd3,  3'd5, 8'd8}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic s, input logic f, input logic [35:0] t, input logic a);
    @(negedge clk);
    bx_sync = s; force_trig = f; ch_trig = t; acq_start = a;
    @(negedge clk);
    bx_sync = 0; force_trig = 0; ch_trig = '0; acq_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 slot", slot_addr, 0);
    chk("R1 bx", bx_now, 0);
    chk("R1 full", mem_full, 0);
    chk("R1 hold", hold, 0);
    rst_n = 1'b1;
    step(0, 0, '0, 1);

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17] ? (36'd1 << VEC[i][16:11]) : 36'd0, 0);
      chk($sformatf("R4/R5/R6 slot v%0d", i), slot_addr, VEC[i][10:8]);
      chk($sformatf("R2 bx v%0d", i), bx_now, VEC[i][7:0]);
      chk($sformatf("R3 hold v%0d", i), hold, VEC[i][19]);
    end
    chk("R8 full", mem_full, 1);

    @(negedge clk);
    chk("R3 hold drop", hold, 0);

    for (int s = 0; s < 5; s++) begin
      rd_slot = 3'(s); #1;
      chk($sformatf("R7/R8 stamp s%0d", s), rd_bx, (s < 2) ? s + 1 : s + 2);
    end
    for (int s = 5; s < 8; s++) begin
      rd_slot = 3'(s); #1;
      chk($sformatf("R9 empty s%0d", s), rd_bx, 0);
    end

    step(1, 1, 36'hF_FFFF_FFFF, 1);
    chk("R10 slot", slot_addr, 0);
    chk("R10 bx", bx_now, 0);
    chk("R10 full", mem_full, 0);
    chk("R10 hold", hold, 0);
    rd_slot = 3'd0; #1;
    chk("R9 cleared slot0", rd_bx, 0);

    step(1, 0, 36'd1 << 20, 0);
    rd_slot = 3'd0; #1;
    chk("R7 new stamp", rd_bx, 0);
    chk("R4 new slot", slot_addr, 1);
    rd_slot = 3'd1; #1;
    chk("R9 slot1 empty", rd_bx, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule